// File: doc/BRIEF.md
# Odd-by-power-of-two slot timebase prescaler

This block turns a fast system clock into a slow timebase: a single-cycle tick that, with the right setting, arrives once per microsecond and paces the bit slots of a serial bus engine. The division ratio is set through one 8-bit divisor register. The ratio is not stored as a plain count. It is the product of an odd factor (1, 3, 5 or 7) and a power of two (1 to 128), so a handful of bits covers every integer-megahertz clock up to well above 100 MHz that such a product can form.

The engine, or a register file in front of it, writes the register with a one-cycle strobe. The written value can be read back at any time. Any write restarts the count from zero, so the first tick after a write comes one full period later. Clearing the enable bit stops the ticks and parks the counters at zero. All pins are plain control and status signals; there is no streamed data and therefore no valid/ready handshake.

For example, a 3 MHz clock uses setting 0x81 (ratio 3) and a 48 MHz clock uses 0x91 (ratio 3 × 16) to reach 1 MHz.

Top module: `slot_tick_prescaler`

## Requirements
- R1: After reset `tick` is low and `cfg_rdata` reads 0x00, so the divider starts disabled.
- R2: After a write strobe, `cfg_rdata` returns the written byte with bits 6 and 5 forced to zero, from the next cycle on.
- R3: While bit 7 of the register is 0, `tick` stays low. Setting bit 7 again restarts the count from zero.
- R4: Bits [1:0] select the odd factor: 0 gives 1, 1 gives 3, 2 gives 5, 3 gives 7.
- R5: Bits [4:2] hold an exponent n that multiplies the ratio by 2^n (0x95 divides by 96, 0x9c by 128, 0x91 by 48).
- R6: With bit 7 set and ratio R = odd × 2^n, `tick` is high for exactly one cycle in every R cycles (every cycle when R = 1).
- R7: A write strobe restarts the count. Counting the cycle right after the strobe cycle as cycle 0, the first tick under the new setting is high in cycle R−1.
- R8: Bits 6 and 5 of a written byte have no effect on the ratio or on the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle write strobe for the divisor register |
| cfg_wdata | input | 8 | Byte written to the divisor register |
| tick | output | 1 | One-cycle timebase pulse |
| cfg_rdata | output | 8 | Readback of the divisor register |

## Verification
The ratio is tried with settings that differ in only one field: each odd factor with n = 0 isolates the odd stage; a fixed odd factor with growing n isolates the power-of-two stage; and 0x91, 0x95, 0x9c and 0x9f exercise both stages together up to the largest ratio of 896. The tick positions are watched over two full periods after each write. This separates a wrong period from an off-by-one restart phase. A write in the middle of a long period tells true restart apart from carrying on with the old count. A disabled spell followed by re-enable shows that the counters were held at zero and not frozen mid-count. A byte with bits 6 and 5 set must give the same timing as the same byte with them clear.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int CFG_W     = 8;
  localparam int SEL_W     = 2;
  localparam int EXP_W     = 3;
  localparam int EN_POS    = 7;
  localparam int SEL_LSB   = 0;
  localparam int EXP_LSB   = SEL_LSB + SEL_W;
  localparam int ODD_CNT_W = SEL_W + 1;
  localparam int POW_CNT_W = (1 << EXP_W) - 1;

  typedef struct packed {
    logic             en;
    logic [EXP_W-1:0] expn;
    logic [SEL_W-1:0] sel;
  } div_cfg_t;

  function automatic div_cfg_t cfg_unpack(input logic [CFG_W-1:0] b);
    div_cfg_t c;
    c.en   = b[EN_POS];
    c.expn = b[EXP_LSB +: EXP_W];
    c.sel  = b[SEL_LSB +: SEL_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input div_cfg_t c);
    logic [CFG_W-1:0] b;
    b                  = '0;
    b[EN_POS]          = c.en;
    b[EXP_LSB +: EXP_W] = c.expn;
    b[SEL_LSB +: SEL_W] = c.sel;
    return b;
  endfunction

  // odd factor minus one: 2*sel
  function automatic logic [ODD_CNT_W-1:0] odd_last(input logic [SEL_W-1:0] s);
    return {s, 1'b0};
  endfunction
endpackage

// File: rtl/prs_cfg_reg.sv
module prs_cfg_reg
  import prs_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output div_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= cfg_unpack(RESET_CFG);
    else if (we) cfg <= cfg_unpack(wdata);
  end

  assign rdata = cfg_pack(cfg);
endmodule

// File: rtl/prs_odd_stage.sv
module prs_odd_stage
  import prs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             wrap
);
  logic [ODD_CNT_W-1:0] cnt;

  assign wrap = (cnt == odd_last(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prs_pow2_stage.sv
module prs_pow2_stage
  import prs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [EXP_W-1:0] expn,
  output logic             wrap
);
  logic [POW_CNT_W-1:0] cnt;
  logic [POW_CNT_W-1:0] last;

  // thermometer mask 2^n - 1
  for (genvar i = 0; i < POW_CNT_W; i++) begin : g_mask
    assign last[i] = (expn > EXP_W'(i));
  end

  assign wrap = step && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/slot_tick_prescaler.sv
module slot_tick_prescaler
  import prs_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             tick,
  output logic [CFG_W-1:0] cfg_rdata
);
  div_cfg_t cfg;
  logic     clr;
  logic     odd_wrap;
  logic     pow_wrap;

  prs_cfg_reg #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  // restart on every write, park at zero while disabled
  assign clr = cfg_we | ~cfg.en;

  prs_odd_stage u_odd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sel(cfg.sel), .wrap(odd_wrap)
  );

  prs_pow2_stage u_pow (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(odd_wrap),
    .expn(cfg.expn), .wrap(pow_wrap)
  );

  assign tick = cfg.en & pow_wrap;
endmodule

// File: rtl/slot_tick_prescaler_chk.sv
module slot_tick_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic       tick,
  input logic [7:0] cfg_rdata
);
  logic [9:0] gap;
  logic [9:0] ratio;

  assign ratio = 10'((({1'b0, cfg_rdata[1:0]} << 1) + 3'd1)) << cfg_rdata[4:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            gap <= '0;
    else if (cfg_we || tick || !cfg_rdata[7]) gap <= '0;
    else                                   gap <= gap + 10'd1;
  end

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |-> !tick);

  // R2 R8
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 8'h9f));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[7] && cfg_wdata[4:0] != 5'd0) |=> !tick);

  // R6
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] |-> (tick == (gap == ratio - 10'd1)));

  // R8
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6:5] == 2'b00);
endmodule

bind slot_tick_prescaler slot_tick_prescaler_chk u_chk (.*);

// File: tb/slot_tick_prescaler_bench.sv
module slot_tick_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       tick;
  logic [7:0] cfg_rdata;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slot_tick_prescaler u_slot_tick_prescaler (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick(tick), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_of(input logic [7:0] d);
    return (2 * int'(d[1:0]) + 1) << d[4:2];
  endfunction

  task automatic write_cfg(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // sample tick over n cycles; period r, phase 0 = first cycle after strobe
  task automatic watch(input int r, input int n, input string req);
    for (int j = 0; j < n; j++) begin
      bit e;
      e = (r > 0) && ((j % r) == r - 1);
      check(tick == e, req, int'(tick), int'(e));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check(tick == 1'b0, "R1 tick", int'(tick), 0);
    check(cfg_rdata == 8'h00, "R1 readback", int'(cfg_rdata), 0);
    watch(0, 20, "R1 idle");
  endtask

  task automatic t_ratio(input logic [7:0] d, input string req);
    write_cfg(d);
    check(cfg_rdata == (d & 8'h9f), "R2 readback", int'(cfg_rdata), int'(d & 8'h9f));
    watch(ratio_of(d), 2 * ratio_of(d), req);
  endtask

  task automatic t_restart;
    write_cfg(8'h9c);
    watch(128, 50, "R7 before rewrite");
    write_cfg(8'h81);
    watch(3, 9, "R7 restart after rewrite");
    write_cfg(8'h81);
    watch(3, 6, "R7 same value rewrite");
  endtask

  task automatic t_disable;
    write_cfg(8'h85);
    watch(6, 4, "R3 running");
    write_cfg(8'h1c);
    check(cfg_rdata == 8'h1c, "R3 readback", int'(cfg_rdata), 8'h1c);
    watch(0, 300, "R3 disabled no tick");
    write_cfg(8'h9c);
    watch(128, 256, "R3 re-enable full period");
  endtask

  task automatic t_spare;
    write_cfg(8'he1);
    check(cfg_rdata == 8'h81, "R8 readback", int'(cfg_rdata), 8'h81);
    watch(3, 9, "R8 spare bits ignored");
    write_cfg(8'h60);
    check(cfg_rdata == 8'h00, "R8 enable unaffected", int'(cfg_rdata), 0);
    watch(0, 10, "R8 spare bits no enable");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratio(8'h80, "R4 R6 odd 1 every cycle");
    t_ratio(8'h81, "R4 odd 3");
    t_ratio(8'h82, "R4 odd 5");
    t_ratio(8'h83, "R4 odd 7");
    t_ratio(8'h84, "R5 n=1");
    t_ratio(8'h8c, "R5 n=3");
    t_ratio(8'h91, "R5 R6 ratio 48");
    t_ratio(8'h95, "R5 R6 ratio 96");
    t_ratio(8'h9c, "R5 R6 ratio 128");
    t_ratio(8'h9f, "R5 R6 ratio 896");
    t_restart();
    t_disable();
    t_spare();
    finish_run();
  end
endmodule